// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when one analog-to-digital conversion begins and which input channel it samples. A conversion can be requested in three ways. Software can pulse a start input. An external pin can fire on a chosen edge, but only once that edge passes a stability filter. A PWM pulse can fire after a programmable delay. Each request is checked against the converter enable, the hardware-trigger enable, the trigger-source select and the current busy state.

When a request is accepted, the block emits a one-cycle start pulse to the converter and presents the lowest-numbered enabled channel. It then holds busy until the converter returns its done strobe. Requests that arrive while busy are dropped rather than queued.

Top module: `adc_trig_seq`

## Requirements
- R1: With conv_en_i=1, busy_o=0 and a non-empty chan_mask_i, a sw_start_i high at a clock edge makes start_o high for exactly the following cycle.
- R2: busy_o rises with start_o and stays high until the edge after conv_done_i is sampled high, or the edge after conv_en_i is sampled low.
- R3: With trig_src_i=2'b00, trig_en_i=1 and edge_rise_i=1, a 0-to-1 change on ext_pin_i that follows at least 4 sampled lows makes start_o high after the fifth clock edge that samples the new level.
- R4: edge_rise_i selects the polarity (1 = rising, 0 = falling). An edge of the other polarity never starts a conversion.
- R5: An external edge is ignored if the new level is held for fewer than 4 samples, or if the old level was held for fewer than 4 samples.
- R6: With trig_src_i=2'b11 and trig_en_i=1, a pwm_trig_i sampled high at edge k makes start_o high after edge k+4*pwm_dly_i. With pwm_dly_i=0 this is the cycle right after the trigger. A trigger arriving while a delay is running is ignored.
- R7: chan_o gives the index of the lowest set bit of chan_mask_i at the accepted start, and holds it until the next start.
- R8: With trig_en_i=0, or with trig_src_i set to 2'b01 or 2'b10, neither ext_pin_i nor pwm_trig_i starts a conversion. Software start still works.
- R9: With conv_en_i=0, no conversion starts from any source.
- R10: A software, pin or PWM trigger that arrives while busy_o=1 is ignored. It does not re-pulse start_o, does not change chan_o and does not arm a delayed start.
- R11: A request made while chan_mask_i is zero does not assert start_o and leaves busy_o low.
- R12: After reset, start_o=0, busy_o=0 and chan_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Converter enable |
| trig_en_i | input | 1 | Hardware trigger enable |
| trig_src_i | input | 2 | Hardware source: 00 pin, 11 PWM, other codes none |
| edge_rise_i | input | 1 | Pin edge polarity: 1 rising, 0 falling |
| pwm_dly_i | input | 8 | PWM start delay in units of 4 clocks |
| chan_mask_i | input | 8 | Channel enable mask, bit i enables channel i |
| sw_start_i | input | 1 | Software start request |
| ext_pin_i | input | 1 | External trigger pin |
| pwm_trig_i | input | 1 | PWM trigger pulse |
| conv_done_i | input | 1 | Conversion finished strobe from the converter |
| start_o | output | 1 | One-cycle start pulse to the converter |
| chan_o | output | 3 | Channel index for the current conversion |
| busy_o | output | 1 | Conversion in progress |

## Verification
A stuck or miscounted stability counter shows up at start_o. The pulse comes one or more cycles off the fifth-sample point, or a short glitch produces a pulse, and either is visible within a few cycles of the pin change. A delay counter that loads the wrong value or decrements wrongly moves the PWM start away from cycle 4N. A missing busy gate shows as a second start_o pulse, or as a chan_o change during a conversion. A bad priority encoder shows a wrong chan_o on the same cycle as start_o.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_NONE1 = 2'b01,
    SRC_NONE2 = 2'b10,
    SRC_PWM  = 2'b11
  } trig_src_e;
endpackage

// File: rtl/adc_pin_qual.sv
`timescale 1ns/1ps
module adc_pin_qual #(
  parameter int STABLE = 4,
  localparam int CW = $clog2(STABLE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          old_ok_q;
  logic          edge_q;
  logic          edge_d;

  // fires on the STABLE-th sample of the new level
  assign edge_d = (pin_i == lvl_q) && (cnt_q == CW'(STABLE - 1)) &&
                  old_ok_q && (lvl_q == rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      cnt_q    <= '0;
      old_ok_q <= 1'b0;
      edge_q   <= 1'b0;
    end else begin
      edge_q <= edge_d;
      if (pin_i != lvl_q) begin
        lvl_q    <= pin_i;
        cnt_q    <= CW'(1);
        old_ok_q <= (cnt_q >= CW'(STABLE));
      end else if (cnt_q != CW'(STABLE)) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign edge_o = edge_q;

  generate
    if (STABLE == 4) begin : g_chk
      p_stable_levels_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |-> ($past(pin_i, 1) == $past(pin_i, 4)) &&
                   ($past(pin_i, 2) == $past(pin_i, 4)) &&
                   ($past(pin_i, 3) == $past(pin_i, 4)) &&
                   ($past(pin_i, 5) != $past(pin_i, 4)) &&
                   ($past(pin_i, 5) == $past(pin_i, 8)) &&
                   ($past(pin_i, 6) == $past(pin_i, 8)) &&
                   ($past(pin_i, 7) == $past(pin_i, 8)));
    end
  endgenerate
endmodule

// File: rtl/adc_pwm_delay.sv
`timescale 1ns/1ps
module adc_pwm_delay #(
  parameter int DW    = 8,
  parameter int SHIFT = 2,
  localparam int CW   = DW + SHIFT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          accept_i,
  input  logic          trig_i,
  input  logic [DW-1:0] dly_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;
  logic          take;

  assign take   = arm_i && accept_i && trig_i && (cnt_q == '0);
  assign fire_o = arm_i && ((cnt_q == CW'(1)) || (take && (dly_i == '0)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!arm_i)          cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
    else if (take && (dly_i != '0))
      cnt_q <= {dly_i, {SHIFT{1'b0}}};
  end

  p_count_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  p_disarm_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (cnt_q == '0));
endmodule

// File: rtl/adc_chan_prio.sv
`timescale 1ns/1ps
module adc_chan_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_trig_seq.sv
`timescale 1ns/1ps
module adc_trig_seq #(
  parameter int N      = 8,
  parameter int DW     = 8,
  parameter int STABLE = 4,
  localparam int IW    = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_en_i,
  input  logic          trig_en_i,
  input  logic [1:0]    trig_src_i,
  input  logic          edge_rise_i,
  input  logic [DW-1:0] pwm_dly_i,
  input  logic [N-1:0]  chan_mask_i,
  input  logic          sw_start_i,
  input  logic          ext_pin_i,
  input  logic          pwm_trig_i,
  input  logic          conv_done_i,
  output logic          start_o,
  output logic [IW-1:0] chan_o,
  output logic          busy_o
);
  import adc_trig_pkg::*;

  trig_src_e     src;
  logic          hw_armed, pin_sel, pwm_sel;
  logic          pin_edge, pwm_fire, hw_fire, start_req;
  logic          sel_any;
  logic [IW-1:0] sel_idx;
  logic          busy_q, start_q;
  logic [IW-1:0] chan_q;

  assign src      = trig_src_e'(trig_src_i);
  assign hw_armed = conv_en_i && trig_en_i;
  assign pin_sel  = (src == SRC_PIN);
  assign pwm_sel  = (src == SRC_PWM);

  adc_pin_qual #(.STABLE(STABLE)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_i (edge_rise_i),
    .edge_o (pin_edge)
  );

  adc_pwm_delay #(.DW(DW)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (hw_armed && pwm_sel),
    .accept_i (!busy_q),
    .trig_i   (pwm_trig_i),
    .dly_i    (pwm_dly_i),
    .fire_o   (pwm_fire)
  );

  adc_chan_prio #(.N(N)) u_prio (
    .mask_i (chan_mask_i),
    .idx_o  (sel_idx),
    .any_o  (sel_any)
  );

  assign hw_fire   = hw_armed && ((pin_sel && pin_edge) || (pwm_sel && pwm_fire));
  assign start_req = conv_en_i && !busy_q && sel_any && (sw_start_i || hw_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      start_q <= start_req;
      if (start_req) begin
        busy_q <= 1'b1;
        chan_q <= sel_idx;
      end else if (conv_done_i || !conv_en_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign start_o = start_q;
  assign chan_o  = chan_q;
  assign busy_o  = busy_q;

  function automatic logic lowest_ok(input logic [N-1:0] m, input logic [IW-1:0] c);
    return m[c] && ((m & ((N'(1) << c) - N'(1))) == '0);
  endfunction

  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_busy_with_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  p_done_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && conv_done_i) |=> !busy_o);
  p_lowest_chan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> lowest_ok($past(chan_mask_i), chan_o));
  p_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(conv_en_i));
  p_idle_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_o));
  p_chan_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(chan_o));
  p_mask_nonempty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(|chan_mask_i));
endmodule

// File: tb/tb_adc_trig_seq.sv
`timescale 1ns/1ps
module tb_adc_trig_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       conv_en = 1'b0, trig_en = 1'b0, edge_rise = 1'b1;
  logic [1:0] trig_src = 2'b00;
  logic [7:0] pwm_dly = '0, chan_mask = '0;
  logic       sw_start = 1'b0, ext_pin = 1'b0, pwm_trig = 1'b0, conv_done = 1'b0;
  logic       start_o, busy_o;
  logic [2:0] chan_o;
  int         total = 0, fails = 0;
  logic       seen;

  always #2 clk = ~clk;

  adc_trig_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .conv_en_i(conv_en), .trig_en_i(trig_en),
    .trig_src_i(trig_src), .edge_rise_i(edge_rise), .pwm_dly_i(pwm_dly),
    .chan_mask_i(chan_mask), .sw_start_i(sw_start), .ext_pin_i(ext_pin),
    .pwm_trig_i(pwm_trig), .conv_done_i(conv_done),
    .start_o(start_o), .chan_o(chan_o), .busy_o(busy_o)
  );

  // {mask, expected channel, expected start}
  localparam logic [11:0] VEC [8] = '{
    {8'h01, 3'd0, 1'b1}, {8'h80, 3'd7, 1'b1}, {8'hFF, 3'd0, 1'b1},
    {8'hA0, 3'd5, 1'b1}, {8'h0C, 3'd2, 1'b1}, {8'h00, 3'd0, 1'b0},
    {8'h40, 3'd6, 1'b1}, {8'h12, 3'd1, 1'b1}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_conv();
    conv_done = 1'b1;
    step();
    conv_done = 1'b0;
  endtask

  task automatic watch(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      seen |= start_o;
    end
  endtask

  initial begin
    #400000;
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R12 start_o", start_o, 0);
    check("R12 busy_o", busy_o, 0);
    check("R12 chan_o", chan_o, 0);
    rst_ni = 1'b1;
    step();
    conv_en = 1'b1;

    // R1 R7 R11: software start across masks
    for (int v = 0; v < 8; v++) begin
      chan_mask = VEC[v][11:4];
      sw_start = 1'b1;
      step();
      sw_start = 1'b0;
      check("R1 start_o", start_o, int'(VEC[v][0]));
      if (VEC[v][0]) begin
        check("R7 chan_o", chan_o, int'(VEC[v][3:1]));
        check("R2 busy_o set", busy_o, 1);
        step();
        check("R1 pulse width", start_o, 0);
        check("R2 busy held", busy_o, 1);
        finish_conv();
        check("R2 busy cleared", busy_o, 0);
      end else begin
        check("R11 busy_o", busy_o, 0);
      end
    end

    // R10: software trigger while busy
    chan_mask = 8'h04;
    sw_start = 1'b1; step(); sw_start = 1'b0;
    check("R10 first start", start_o, 1);
    chan_mask = 8'h01;
    sw_start = 1'b1; step(); sw_start = 1'b0;
    check("R10 no restart", start_o, 0);
    check("R10 chan held", chan_o, 2);
    finish_conv();

    // R10: PWM trigger while busy does not arm
    trig_src = 2'b11; trig_en = 1'b1; pwm_dly = 8'd1;
    sw_start = 1'b1; step(); sw_start = 1'b0;
    pwm_trig = 1'b1; step(); pwm_trig = 1'b0;
    finish_conv();
    seen = 1'b0; watch(8);
    check("R10 pwm while busy", seen, 0);

    // R2: disable clears busy
    sw_start = 1'b1; step(); sw_start = 1'b0;
    conv_en = 1'b0; step();
    check("R2 busy cleared by disable", busy_o, 0);

    // R9: disabled converter
    sw_start = 1'b1; step(); sw_start = 1'b0;
    check("R9 start_o", start_o, 0);
    check("R9 busy_o", busy_o, 0);
    conv_en = 1'b1;

    // R6: PWM delay 0 and 2
    pwm_dly = 8'd0;
    pwm_trig = 1'b1; step(); pwm_trig = 1'b0;
    check("R6 zero delay", start_o, 1);
    finish_conv();
    pwm_dly = 8'd2;
    pwm_trig = 1'b1; step(); pwm_trig = 1'b0;
    seen = 1'b0; watch(7);
    check("R6 early start", seen, 0);
    step();
    check("R6 delay 8", start_o, 1);
    finish_conv();

    // R3: rising edge on pin
    trig_src = 2'b00; edge_rise = 1'b1; ext_pin = 1'b0;
    repeat (6) step();
    ext_pin = 1'b1;
    seen = 1'b0; watch(4);
    check("R3 early start", seen, 0);
    step();
    check("R3 fifth sample start", start_o, 1);
    finish_conv();

    // R4: falling edge ignored in rising mode, then falling mode
    repeat (6) step();
    ext_pin = 1'b0;
    seen = 1'b0; watch(10);
    check("R4 wrong polarity", seen, 0);
    edge_rise = 1'b0;
    ext_pin = 1'b1;
    seen = 1'b0; watch(6);
    check("R4 rise in falling mode", seen, 0);
    ext_pin = 1'b0;
    watch(4);
    check("R4 falling early", seen, 0);
    step();
    check("R4 falling start", start_o, 1);
    finish_conv();

    // R5: short new level, then short old level
    edge_rise = 1'b1;
    repeat (6) step();
    ext_pin = 1'b1; step(); step();
    ext_pin = 1'b0;
    seen = 1'b0; watch(10);
    check("R5 short pulse", seen, 0);
    edge_rise = 1'b0;
    ext_pin = 1'b1;
    seen = 1'b0; watch(8);
    edge_rise = 1'b1;
    ext_pin = 1'b0; watch(2);
    ext_pin = 1'b1; watch(10);
    check("R5 short old level", seen, 0);

    // R8: hardware enable off, then reserved source codes
    trig_en = 1'b0;
    ext_pin = 1'b0; seen = 1'b0; watch(6);
    ext_pin = 1'b1; watch(10);
    check("R8 pin with trig_en=0", seen, 0);
    trig_src = 2'b11; pwm_dly = 8'd0;
    pwm_trig = 1'b1; step(); pwm_trig = 1'b0;
    seen = start_o; watch(3);
    check("R8 pwm with trig_en=0", seen, 0);
    trig_en = 1'b1; trig_src = 2'b01;
    ext_pin = 1'b0; seen = 1'b0; watch(6);
    ext_pin = 1'b1; watch(10);
    trig_src = 2'b10;
    pwm_trig = 1'b1; step(); pwm_trig = 1'b0;
    seen |= start_o; watch(3);
    check("R8 reserved sources", seen, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule